// File: doc/BRIEF.md
# Buffered SPI Master

This block is a single-select SPI master with a small memory-mapped register file. Software writes a byte into a one-deep transmit holding register. The block moves that byte into its shift register as soon as the shifter is free. It then sends the byte MSB first on MOSI while it captures MISO, with SCLK idle low, and holds the slave select low for the whole word. Each received byte lands in a receive data register.

A status register reports the state of both sides. It shows whether the holding register can take a byte, whether a received byte is waiting, and whether the shifter is idle. It also shows two overrun errors and their OR. A control register holds one interrupt enable per status bit, and the interrupt output is high when any enabled status bit is set. Software can therefore run the block by polling, or it can leave it to run from the interrupt.

Top module: `spim_buf`

## Requirements
- R1: After reset the status register reads 0x0060 (TRDY and TMT set, all else 0), the control register reads 0, ss_no is high, sclk_o is low and irq_o is low.
- R2: A word is 8 bits, MSB first, with SCLK idle low. MOSI changes only on falling SCLK and MISO is sampled on rising SCLK. Each SCLK half-period lasts HALF_DIV clock cycles, and ss_no stays low for exactly 16*HALF_DIV cycles per word.
- R3: TRDY (status bit 6) is 1 when the holding register is empty. A byte written while the shifter is idle starts shifting on the next cycle, so TRDY reads 0 for one cycle. A byte written while a word is shifting waits, and TRDY reads 0 until that word ends and the held byte starts.
- R4: A write to txdata while TRDY is 0 sets TOE (status bit 4). The written byte is discarded and the held byte is still sent.
- R5: RRDY (status bit 7) rises one cycle after ss_no returns high at the end of a word. A read of rxdata clears it. If a read of rxdata and a word completion fall in the same cycle, RRDY stays 1 and ROE is not set.
- R6: A word completing while RRDY is 1 and rxdata is not being read sets ROE (status bit 3), and the new byte replaces the old one in rxdata.
- R7: TMT (status bit 5) is 1 only when no word is shifting and the holding register is empty.
- R8: E (status bit 8) equals TOE OR ROE.
- R9: Any write to status, whatever its data, clears ROE, TOE and E. A read of status changes nothing. If an error event falls in the same cycle as the write, the error is set.
- R10: Control bits 8..3 enable the status bits at the same positions, and irq_o is the OR of the enabled status bits that are set.
- R11: Addresses: 0 is rxdata (read, byte in bits 7..0), 1 is txdata (write, bits 7..0), 2 is status, 3 is control (reads back its enables in bits 8..3). All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect only on rxdata) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Slave select, active low |

## Verification
A holding-register flag stuck at the wrong value shows at the ports within one cycle: TRDY and TMT are wrong, or a word starts late, early or twice on ss_no. A wrong shift or capture register does not show at once. It appears at the end of a word, either as a byte on MOSI that differs from the one accepted, or as a wrong value in rxdata at the next read. Mistakes in the flag set or clear rules show in the status read and on irq_o in the cycle after the event. The same-cycle cases are the completion together with an rxdata read and an error event together with a status write.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int B_ROE = 3;
  localparam int B_ERR = 8;

  // packed order gives bit 8 (err) down to bit 3 (roe)
  typedef struct packed {
    logic err;
    logic rrdy;
    logic trdy;
    logic tmt;
    logic toe;
    logic roe;
  } stat_t;
endpackage

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_no,
  input  logic              miso_i
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, sclk_q, done_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_word_q;
  logic              tick;

  assign tick = (div_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      bit_q     <= '0;
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        busy_q  <= 1'b1;
        tx_sh_q <= load_data_i;
        bit_q   <= '0;
        div_q   <= '0;
        sclk_q  <= 1'b0;
      end else if (busy_q) begin
        if (!tick) begin
          div_q <= div_q + 1'b1;
        end else begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q  <= 1'b1;
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              busy_q    <= 1'b0;
              done_q    <= 1'b1;
              rx_word_q <= rx_sh_q;
            end else begin
              bit_q   <= bit_q + 1'b1;
              tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_word_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sh_q[WORD_W-1];
  assign ss_no     = ~busy_q;

  a_r2_no_load_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  a_r2_sclk_low_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  a_r2_mosi_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$fell(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_sel_e          sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              load_o,
  output logic [WORD_W-1:0] load_data_o
);
  logic              hold_full_q, rrdy_q, roe_q, toe_q;
  logic [WORD_W-1:0] hold_q, rx_q;
  stat_t             ctrl_q, stat;
  logic              wr_tx, wr_st, wr_ct, rd_rx;
  logic              unused_wbits;

  assign wr_tx = wr_i && (sel_i == REG_TX);
  assign wr_st = wr_i && (sel_i == REG_STAT);
  assign wr_ct = wr_i && (sel_i == REG_CTRL);
  assign rd_rx = rd_i && (sel_i == REG_RX);
  assign unused_wbits = ^wdata_i[DATA_W-1:B_ERR+1];

  assign load_o      = hold_full_q && !busy_i;
  assign load_data_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      rx_q        <= '0;
      rrdy_q      <= 1'b0;
      roe_q       <= 1'b0;
      toe_q       <= 1'b0;
      ctrl_q      <= '0;
    end else begin
      if (load_o) hold_full_q <= 1'b0;
      else if (wr_tx && !hold_full_q) begin
        hold_full_q <= 1'b1;
        hold_q      <= wdata_i[WORD_W-1:0];
      end

      if (wr_tx && hold_full_q) toe_q <= 1'b1;
      else if (wr_st)           toe_q <= 1'b0;

      if (done_i && rrdy_q && !rd_rx) roe_q <= 1'b1;
      else if (wr_st)                 roe_q <= 1'b0;

      if (done_i)     rrdy_q <= 1'b1;
      else if (rd_rx) rrdy_q <= 1'b0;

      if (done_i) rx_q <= rx_word_i;
      if (wr_ct)  ctrl_q <= wdata_i[B_ERR:B_ROE];
    end
  end

  always_comb begin
    stat.err  = toe_q | roe_q;
    stat.rrdy = rrdy_q;
    stat.trdy = ~hold_full_q;
    stat.tmt  = ~busy_i & ~hold_full_q;
    stat.toe  = toe_q;
    stat.roe  = roe_q;
  end

  assign irq_o = |(stat & ctrl_q);

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      REG_RX:   rdata_o[WORD_W-1:0]  = rx_q;
      REG_TX:   rdata_o              = '0;
      REG_STAT: rdata_o[B_ERR:B_ROE] = stat;
      REG_CTRL: rdata_o[B_ERR:B_ROE] = ctrl_q;
      default:  rdata_o              = '0;
    endcase
  end

  a_r3_hold_starts_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !busy_i) |=> (busy_i && !hold_full_q));
  a_r4_toe_on_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && hold_full_q) |=> (toe_q && $stable(hold_q)));
  a_r5_done_sets_rrdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rrdy_q);
  a_r6_roe_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rrdy_q && !rd_rx) |=> roe_q);
  a_r9_status_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && !(done_i && rrdy_q)) |=> (!roe_q && !toe_q));
endmodule

// File: rtl/spim_buf.sv
module spim_buf
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        ss_no
);
  localparam int WORD_W = 8;

  logic              busy, done, load;
  logic [WORD_W-1:0] rx_word, load_data;

  spim_regs #(.WORD_W(WORD_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (reg_sel_e'(addr_i)),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o),
    .busy_i      (busy),
    .done_i      (done),
    .rx_word_i   (rx_word),
    .load_o      (load),
    .load_data_o (load_data)
  );

  spim_shift #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (load_data),
    .busy_o      (busy),
    .done_o      (done),
    .rx_word_o   (rx_word),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .ss_no       (ss_no),
    .miso_i      (miso_i)
  );
endmodule

// File: tb/spim_buf_bench.sv
module spim_buf_bench;
  localparam int HALF = 2;
  localparam int WORD_CYC = 16 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, sclk, mosi, ss_n;
  logic        miso = 1'b0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  spim_buf #(.HALF_DIV(HALF)) u_spim_buf (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] slave_byte(input int n);
    return 8'((n * 37 + 8'h5a) & 255);
  endfunction

  // reference model
  int          m_left, m_words;
  bit          m_done, m_hold_full, m_rrdy, m_roe, m_toe;
  logic [7:0]  m_cur_rx, m_done_rx, m_rx;
  logic [15:0] m_ctrl;
  logic [7:0]  exp_tx[$];

  function automatic logic [15:0] m_status();
    logic [15:0] s;
    s = '0;
    s[3] = m_roe;
    s[4] = m_toe;
    s[5] = (m_left == 0) && !m_hold_full;
    s[6] = !m_hold_full;
    s[7] = m_rrdy;
    s[8] = m_roe | m_toe;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_words = 0; m_done = 0; m_hold_full = 0;
      m_rrdy = 0; m_roe = 0; m_toe = 0; m_rx = 0; m_ctrl = 0;
      m_cur_rx = 0; m_done_rx = 0;
    end else begin
      automatic bit rd_rx = rd && addr == 2'd0;
      automatic bit wr_tx = wr && addr == 2'd1;
      automatic bit wr_st = wr && addr == 2'd2;
      automatic bit wr_ct = wr && addr == 2'd3;
      automatic bit load  = m_hold_full && m_left == 0;
      automatic bit done  = m_done;
      m_done = 0;
      if (load) begin
        m_left = WORD_CYC;
        m_cur_rx = slave_byte(m_words);
        m_words++;
      end else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_done = 1; m_done_rx = m_cur_rx; end
      end
      if (wr_tx && m_hold_full) m_toe = 1;
      else if (wr_st) m_toe = 0;
      if (done && m_rrdy && !rd_rx) m_roe = 1;
      else if (wr_st) m_roe = 0;
      if (done) begin m_rrdy = 1; m_rx = m_done_rx; end
      else if (rd_rx) m_rrdy = 0;
      if (load) m_hold_full = 0;
      else if (wr_tx && !m_hold_full) begin
        m_hold_full = 1;
        exp_tx.push_back(wdata[7:0]);
      end
      if (wr_ct) m_ctrl = wdata & 16'h01f8;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      automatic logic [15:0] s = m_status();
      chk(ss_n == (m_left == 0), "R2 ss_no", int'(ss_n), int'(m_left == 0));
      chk(irq == |(s & m_ctrl), "R10 irq", int'(irq), int'(|(s & m_ctrl)));
      if (addr == 2'd2 && !wr) begin
        chk(rdata[3] == s[3], "R6 ROE", int'(rdata[3]), int'(s[3]));
        chk(rdata[4] == s[4], "R4 TOE", int'(rdata[4]), int'(s[4]));
        chk(rdata[5] == s[5], "R7 TMT", int'(rdata[5]), int'(s[5]));
        chk(rdata[6] == s[6], "R3 TRDY", int'(rdata[6]), int'(s[6]));
        chk(rdata[7] == s[7], "R5 RRDY", int'(rdata[7]), int'(s[7]));
        chk(rdata[8] == s[8], "R8 E", int'(rdata[8]), int'(s[8]));
        chk((rdata & 16'hfe07) == 0, "R11 status spare bits", int'(rdata), 0);
      end
    end
  end

  // slave side
  int         s_words = 0;
  logic [7:0] s_tx = '0, s_rx = '0;
  realtime    t_rise = 0;

  always @(negedge ss_n) if (rst_n) begin
    s_tx = slave_byte(s_words);
    s_words++;
    s_rx = '0;
    miso = s_tx[7];
  end
  always @(posedge sclk) begin
    s_rx = {s_rx[6:0], mosi};
    t_rise = $realtime;
  end
  always @(negedge sclk) if (rst_n) begin
    chk($realtime - t_rise == HALF * 4.0, "R2 sclk high time",
        int'($realtime - t_rise), HALF * 4);
    s_tx = {s_tx[6:0], 1'b0};
    miso = s_tx[7];
  end
  always @(posedge ss_n) if (rst_n && exp_tx.size() > 0) begin
    automatic logic [7:0] e = exp_tx.pop_front();
    chk(s_rx == e, "R2 mosi byte", int'(s_rx), int'(e));
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [15:0] e, input string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 chk(rdata == e, req, int'(rdata), int'(e));
    @(negedge clk);
    rd = 1'b0; addr = 2'd2;
  endtask

  task automatic wait_idle();
    while (!(m_left == 0 && !m_hold_full && !m_done)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rdata == 16'h0060, "R1 status after reset", int'(rdata), 16'h0060);
    chk(ss_n == 1'b1 && sclk == 1'b0, "R1 serial idle", int'({ss_n, sclk}), 2);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    bus_rd(2'd3, 16'h0000, "R1 control after reset");

    // single word from idle: TRDY low one cycle (R3)
    bus_wr(2'd1, 16'h00a5);
    #1 chk(rdata[6] == 1'b0, "R3 TRDY low after write", int'(rdata[6]), 0);
    @(negedge clk); #1;
    chk(rdata[6] == 1'b1, "R3 TRDY back high", int'(rdata[6]), 1);
    wait_idle();
    bus_rd(2'd0, {8'h00, m_rx}, "R5 rx data word 0");
    chk(m_rx == slave_byte(0), "R5 model rx", int'(m_rx), int'(slave_byte(0)));
    bus_rd(2'd2, 16'h0060, "R5 RRDY cleared by read");

    // back-to-back, third write overruns (R4), second completion overruns rx (R6)
    bus_wr(2'd1, 16'h0011);
    bus_wr(2'd1, 16'h0022);
    bus_wr(2'd1, 16'h0033);
    bus_rd(2'd2, 16'h0110, "R4 TOE and E set, TRDY low");
    wait_idle();
    bus_rd(2'd2, 16'h01f8 & 16'h01f8, "R6 ROE, TOE, RRDY, E all set");
    bus_rd(2'd0, {8'h00, slave_byte(2)}, "R6 newest byte kept");

    // status reads have no effect; write of any data clears errors (R9)
    bus_rd(2'd2, 16'h0178, "R9 status read unchanged");
    bus_wr(2'd2, 16'h0000);
    bus_rd(2'd2, 16'h0060, "R9 write 0 clears errors");
    bus_wr(2'd1, 16'h0044);
    bus_wr(2'd1, 16'h0045);
    bus_wr(2'd1, 16'h0046);
    wait_idle();
    bus_wr(2'd2, 16'hffff);
    bus_rd(2'd2, 16'h00e0, "R9 write ffff clears errors");
    bus_rd(2'd0, {8'h00, slave_byte(4)}, "R5 rx after pair");

    // interrupt enables (R10, R11)
    bus_wr(2'd3, 16'hffff);
    bus_rd(2'd3, 16'h01f8, "R11 control readback");
    chk(irq == 1'b1, "R10 irq with TRDY enabled", int'(irq), 1);
    bus_wr(2'd3, 16'h0080);
    chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    bus_wr(2'd1, 16'h005c);
    wait_idle();
    chk(irq == 1'b1, "R10 irq on RRDY", int'(irq), 1);

    // rxdata read in the completion cycle (R5): RRDY stays, no ROE
    bus_wr(2'd1, 16'h00c3);
    @(posedge ss_n);
    @(negedge clk);
    addr = 2'd0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; addr = 2'd2;
    #1;
    chk(rdata[7] == 1'b1 && rdata[3] == 1'b0, "R5 same-cycle read and completion",
        int'(rdata[8:3]), int'(m_status() >> 3));
    bus_rd(2'd0, {8'h00, slave_byte(6)}, "R5 rx after same-cycle case");
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule